// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital half of a dual-slope analog-to-digital converter. The integrator, comparator, analog switch and reference are external. A start request in the idle state begins a conversion. The block first routes the unknown input to the integrator for a fixed run-up of 2^W counted clocks, measured by a single W-bit counter. When that counter wraps to zero, the block moves the switch to the negative reference. It then counts the run-down with the same counter until the comparator reports that the integrator has crossed zero. The final count is proportional to the input over the reference, about 2^W·Va/VR.

Clocks reach the counter only while the comparator, after a two-flop synchronizer, reads high. The two-clock synchronizer latency appears the same way at both ends of the conversion. If the run-down reaches 2^W counts, the result saturates and an overflow flag is set. After each conversion the block holds both switches open for a fixed auto-zero interval before it accepts another start.

Top module: `ds_adc_seq`

## Requirements
- R1: After reset, busy_o, done_o, sw_in_o, sw_ref_o and ovf_o are 0 and result_o is 0.
- R2: A start_i high at a clock edge while idle makes busy_o and sw_in_o high after that edge. Start pulses while busy have no effect on the conversion or its timing.
- R3: sw_in_o and sw_ref_o are never high in the same cycle.
- R4: Suppose the comparator input goes high on the first run-up cycle. Then sw_in_o stays high for exactly 2^W + 2 cycles, and each cycle in which cmp_i is sampled low during run-up adds one cycle. When run-up ends, the counter has wrapped to zero and sw_ref_o rises.
- R5: Let P be the number of cycles in which cmp_i is high while sw_ref_o is high, followed by a low. If P + 2 < 2^W, then result_o = P + 2, where the 2 covers the two samples still in the synchronizer. done_o pulses high for exactly one cycle, and sw_ref_o falls in that same cycle.
- R6: If the run-down count reaches 2^W, the conversion ends with result_o all ones and ovf_o = 1. A result of 2^W − 1 reached by a comparator fall reports ovf_o = 0.
- R7: From the done_o cycle, busy_o stays high for AZ_CYC cycles with both switches low, and start pulses are ignored. Then busy_o falls.
- R8: result_o and ovf_o hold their values from one done_o pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken only while idle |
| cmp_i | input | 1 | Comparator: integrator still on the active side of zero |
| sw_in_o | output | 1 | Route the unknown input to the integrator |
| sw_ref_o | output | 1 | Route the negative reference to the integrator |
| busy_o | output | 1 | Conversion or auto-zero in progress |
| done_o | output | 1 | One-cycle pulse when a result is captured |
| ovf_o | output | 1 | Last conversion saturated |
| result_o | output | W | Last conversion count |

## Verification
A wrong state in this block shows up at the switch outputs almost at once. The bench counts the exact length of each switch phase, so a counter that misses or adds one clock, or a gating slip, changes that length by one cycle and is reported at the end of that phase. A fault in the comparator path shows in the result at done_o, as an error of one or two codes. A fault in the auto-zero timer shows as a busy_o interval of the wrong length, which the bench sees before the next start.

// File: rtl/ds_adc_pkg.sv
package ds_adc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RUNUP = 2'd1,
      PH_RUNDN = 2'd2,
      PH_AZERO = 2'd3
   } ds_phase_e;
endpackage

// File: rtl/ds_sync_chain.sv
module ds_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ds_sync_chain needs at least two stages");
   end

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ds_gated_counter.sv
module ds_gated_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (en_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign last_o = en_i & (&cnt_q);
endmodule

// File: rtl/ds_phase_ctrl.sv
module ds_phase_ctrl
   import ds_adc_pkg::*;
#(
   parameter int W      = 8,
   parameter int AZ_CYC = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         cmp_s_i,
   input  logic [W-1:0] cnt_i,
   input  logic         last_i,
   output logic         cnt_clr_o,
   output logic         cnt_en_o,
   output logic         sw_in_o,
   output logic         sw_ref_o,
   output logic         busy_o,
   output logic         done_o,
   output logic         ovf_o,
   output logic [W-1:0] result_o
);
   localparam int AZ_W = (AZ_CYC > 1) ? $clog2(AZ_CYC) : 1;
   localparam logic [AZ_W-1:0] AZ_LAST = AZ_W'(AZ_CYC - 1);

   ds_phase_e     phase_q;
   logic [AZ_W-1:0] az_q;
   logic          done_q, ovf_q;
   logic [W-1:0]  res_q;

   assign cnt_en_o  = ((phase_q == PH_RUNUP) || (phase_q == PH_RUNDN)) && cmp_s_i;
   assign cnt_clr_o = (phase_q == PH_IDLE) && start_i;
   assign sw_in_o   = (phase_q == PH_RUNUP);
   assign sw_ref_o  = (phase_q == PH_RUNDN);
   assign busy_o    = (phase_q != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         az_q    <= '0;
         done_q  <= 1'b0;
         ovf_q   <= 1'b0;
         res_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE:  if (start_i) phase_q <= PH_RUNUP;
            PH_RUNUP: if (last_i)  phase_q <= PH_RUNDN;
            PH_RUNDN: begin
               if (!cmp_s_i) begin
                  res_q   <= cnt_i;
                  ovf_q   <= 1'b0;
                  done_q  <= 1'b1;
                  az_q    <= '0;
                  phase_q <= PH_AZERO;
               end else if (last_i) begin
                  res_q   <= '1;
                  ovf_q   <= 1'b1;
                  done_q  <= 1'b1;
                  az_q    <= '0;
                  phase_q <= PH_AZERO;
               end
            end
            default: begin
               if (az_q == AZ_LAST) phase_q <= PH_IDLE;
               else                 az_q    <= az_q + 1'b1;
            end
         endcase
      end
   end

   assign done_o   = done_q;
   assign ovf_o    = ovf_q;
   assign result_o = res_q;

   // R2
   start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && start_i) |=> (sw_in_o && busy_o));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/ds_adc_seq.sv
module ds_adc_seq #(
   parameter int W      = 8,
   parameter int AZ_CYC = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         cmp_i,
   output logic         sw_in_o,
   output logic         sw_ref_o,
   output logic         busy_o,
   output logic         done_o,
   output logic         ovf_o,
   output logic [W-1:0] result_o
);
   localparam int SYNC_STAGES = 2;

   if (W < 2 || W > 24) begin : g_bad_w
      $error("ds_adc_seq: W must lie in 2..24");
   end
   if (AZ_CYC < 4) begin : g_bad_az
      $error("ds_adc_seq: AZ_CYC must be at least 4");
   end

   logic         cmp_s;
   logic         cnt_clr, cnt_en, cnt_last;
   logic [W-1:0] cnt;

   ds_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s));

   ds_gated_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en),
      .cnt_o(cnt), .last_o(cnt_last));

   ds_phase_ctrl #(.W(W), .AZ_CYC(AZ_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_s_i(cmp_s),
      .cnt_i(cnt), .last_i(cnt_last), .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en),
      .sw_in_o(sw_in_o), .sw_ref_o(sw_ref_o), .busy_o(busy_o),
      .done_o(done_o), .ovf_o(ovf_o), .result_o(result_o));

   // R4
   runup_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_ref_o) |-> (cnt == '0));

   // R6
   ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o) |-> (&result_o));

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(ovf_o)));
endmodule

// File: tb/sim_ds_adc_seq.sv
module sim_ds_adc_seq;
   localparam int W  = 8;
   localparam int AZ = 16;
   localparam int FS = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic cmp_i = 1'b0;
   logic sw_in_o, sw_ref_o, busy_o, done_o, ovf_o;
   logic [W-1:0] result_o;

   int n_chk = 0;
   int n_fail = 0;
   int last_res = 0;
   int last_ovf = 0;
   bit have_last = 1'b0;

   always #2 clk = ~clk;

   ds_adc_seq #(.W(W), .AZ_CYC(AZ)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .sw_in_o(sw_in_o), .sw_ref_o(sw_ref_o), .busy_o(busy_o),
      .done_o(done_o), .ovf_o(ovf_o), .result_o(result_o));

   function automatic int exp_runup(int q);
      return FS + 2 + q;
   endfunction

   function automatic int exp_ovf(int p);
      return (p + 2 >= FS) ? 1 : 0;
   endfunction

   function automatic int exp_result(int p);
      return (p + 2 >= FS) ? FS - 1 : p + 2;
   endfunction

   task automatic check_eq(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   // q: comparator-low samples in run-up; p: high samples in run-down
   task automatic run_conv(int q, int p);
      int runup = 0;
      int idx = 0;
      int rd = 0;
      int azc = 0;
      bit both = 1'b0;
      bit sw_in_az = 1'b0;
      while (busy_o) @(negedge clk);
      if (have_last) begin
         check_eq("R8 result held", int'(result_o), last_res);
         check_eq("R8 ovf held", int'(ovf_o), last_ovf);
      end
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check_eq("R2 busy after start", int'(busy_o), 1);
      check_eq("R2 input switch after start", int'(sw_in_o), 1);
      while (sw_in_o) begin
         runup++;
         if (sw_ref_o) both = 1'b1;
         cmp_i   = (idx >= 3 && idx < 3 + q) ? 1'b0 : 1'b1;
         start_i = (idx == 6 || idx == 40) ? 1'b1 : 1'b0;
         idx++;
         @(negedge clk);
      end
      start_i = 1'b0;
      check_eq("R4 run-up length", runup, exp_runup(q));
      check_eq("R4 reference after run-up", int'(sw_ref_o), 1);
      while (sw_ref_o) begin
         if (sw_in_o) both = 1'b1;
         cmp_i = (rd < p) ? 1'b1 : 1'b0;
         start_i = (rd == 5) ? 1'b1 : 1'b0;
         rd++;
         @(negedge clk);
      end
      start_i = 1'b0;
      cmp_i = 1'b0;
      check_eq("R3 switches exclusive", int'(both), 0);
      check_eq("R5 done at release", int'(done_o), 1);
      check_eq("R5/R6 result", int'(result_o), exp_result(p));
      check_eq("R6 overflow flag", int'(ovf_o), exp_ovf(p));
      azc = 1;
      @(negedge clk);
      check_eq("R5 done one cycle", int'(done_o), 0);
      while (busy_o) begin
         azc++;
         if (sw_in_o || sw_ref_o) sw_in_az = 1'b1;
         start_i = (azc == 3) ? 1'b1 : 1'b0;
         @(negedge clk);
      end
      start_i = 1'b0;
      check_eq("R7 auto-zero length", azc, AZ);
      check_eq("R7 switches open in auto-zero", int'(sw_in_az), 0);
      check_eq("R7 start ignored in auto-zero", int'(sw_in_o), 0);
      last_res  = exp_result(p);
      last_ovf  = exp_ovf(p);
      have_last = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 busy", int'(busy_o), 0);
      check_eq("R1 done", int'(done_o), 0);
      check_eq("R1 switches", int'(sw_in_o) + int'(sw_ref_o), 0);
      check_eq("R1 ovf", int'(ovf_o), 0);
      check_eq("R1 result", int'(result_o), 0);
      run_conv(0, 0);
      run_conv(0, FS - 3);
      run_conv(0, FS - 2);
      run_conv(0, 3 * FS);
      run_conv(4, 100);
      run_conv(1, 1);
      for (int i = 0; i < 20; i++) begin
         int q = int'($urandom % 6);
         int p = int'($urandom % (FS + 40));
         run_conv(q, p);
      end
      finish_run();
   end
endmodule